// File: doc/BRIEF.md
# Reloadable Scanline Interrupt Down-Counter

This block counts video scanlines and raises an interrupt after a programmed number of them. A pulse derived from the video address bus arrives once per scanline. On each pulse an 8-bit down-counter either takes a fresh value from a reload latch or steps down by one. When the counter lands on zero while interrupts are enabled, a pending flag sets and drives the interrupt line.

Software programs the block through CPU writes in the upper quarter of the 16-bit address space. Address bit 13 picks between the counter register pair and the enable register pair, and address bit 0 picks the register within the pair. The interrupt is taken by a poll: the poll returns the pending flag and clears it in the same cycle. Filtering of the video address line and any bank mapping sit outside this block.

Top module: `line_irq_counter`

## Requirements
- R1: On a `line_tick` cycle, if the reload request is set or the counter is zero, the counter takes the latch value and the reload request clears; otherwise the counter decrements by one.
- R2: In a `line_tick` cycle, if interrupts are enabled and the counter value after the R1 update is zero, `irq` reads 1 from the next cycle on.
- R3: A write with address bits [15:13] = 3'b110 and bit 0 = 0 stores `wr_data` in the reload latch. A tick in the same cycle still uses the old latch value.
- R4: A write with address bits [15:13] = 3'b110 and bit 0 = 1 clears the counter and sets the reload request.
- R5: A write with address bits [15:13] = 3'b111 and bit 0 = 0 disables interrupts and clears the pending flag, and this clear wins over a set in the same cycle. The same write with bit 0 = 1 enables interrupts from the next cycle on.
- R6: While `poll_req` is high, `poll_pending` shows the pending flag, and the flag is clear in the next cycle unless a set from R2 happens in that same cycle.
- R7: With a latch value of zero and interrupts enabled, every tick sets the pending flag.
- R8: When an R4 write and a tick fall in the same cycle, the write decides the counter and the reload request, and that tick sets no pending flag.
- R9: After reset the latch, counter, reload request, enable and pending flag are all zero, so `irq` is 0.
- R10: Writes with address bits [15:14] other than 2'b11 change nothing. Address bits [12:1] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_tick | input | 1 | One-cycle pulse, once per scanline |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| poll_req | input | 1 | Poll and acknowledge the interrupt |
| poll_pending | output | 1 | Pending flag as seen by the poll |
| irq | output | 1 | Interrupt line, high while pending |

## Verification
The first pattern sweeps every small latch value with a reload request and a long run of ticks. It separates a correct reload-at-zero period of latch+1 ticks from off-by-one variants and from a counter that never reloads. The second pattern is a long pseudo-random mix of ticks, the four register writes, writes outside the decoded range, and polls, often in the same cycle. It exposes wrong priority between a write and a tick, between a set and a poll, and between a set and a disable. Each cycle the interrupt line is compared with a model that the bench keeps from the requirements alone.

// File: rtl/line_irq_pkg.sv
// Package: shared types for the scanline interrupt counter.
// Assumes one decoded register operation per cycle at most.
package line_irq_pkg;

    // Register operation decoded from one CPU write.
    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_LATCH   = 3'd1,
        OP_RELOAD  = 3'd2,
        OP_DISABLE = 3'd3,
        OP_ENABLE  = 3'd4
    } irq_op_e;

endpackage

// File: rtl/line_irq_decode.sv
// Module: line_irq_decode
// Turns a CPU write into one register operation. Only the top two
// address bits, bit (ADDR_W-3) and bit 0 are looked at; the rest is
// ignored. Assumes ADDR_W >= 3.
module line_irq_decode
    import line_irq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output irq_op_e           op
);

    localparam int SEL_BIT = ADDR_W - 3;

    logic in_range;

    // Purpose: pick the register from the write address.
    always_comb begin
        in_range = wr_en && (wr_addr[ADDR_W-1 -: 2] == 2'b11);
        op = OP_NONE;
        if (in_range) begin
            case ({wr_addr[SEL_BIT], wr_addr[0]})
                2'b00:   op = OP_LATCH;
                2'b01:   op = OP_RELOAD;
                2'b10:   op = OP_DISABLE;
                default: op = OP_ENABLE;
            endcase
        end
    end

endmodule

// File: rtl/line_irq_count.sv
// Module: line_irq_count
// Holds the reload latch, the down-counter and the reload request.
// On a tick the counter reloads (request set or counter zero) or
// decrements. A reload write in the same cycle overrides the tick.
// Reports a tick that leaves the counter at zero.
module line_irq_count
    import line_irq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  irq_op_e          op,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             line_tick,
    output logic             tick_zero
);

    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] latch_q;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             rel_q, rel_d;

    // Purpose: reload latch write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= ZERO;
        else if (op == OP_LATCH)
            latch_q <= wr_data;
    end

    // Purpose: next counter and reload request, CPU write first.
    always_comb begin
        cnt_d     = cnt_q;
        rel_d     = rel_q;
        tick_zero = 1'b0;
        if (op == OP_RELOAD) begin
            cnt_d = ZERO;
            rel_d = 1'b1;
        end else if (line_tick) begin
            if (rel_q || (cnt_q == ZERO)) begin
                cnt_d = latch_q;
                rel_d = 1'b0;
            end else begin
                cnt_d = cnt_q - ONE;
            end
            tick_zero = (cnt_d == ZERO);
        end
    end

    // Purpose: counter and reload request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= ZERO;
            rel_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            rel_q <= rel_d;
        end
    end

    AST_RELOAD_TAKES_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (line_tick && op != OP_RELOAD && (rel_q || cnt_q == ZERO))
        |=> (cnt_q == $past(latch_q) && !rel_q)); // R1

    AST_TICK_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (line_tick && op != OP_RELOAD && !rel_q && cnt_q != ZERO)
        |=> (cnt_q == $past(cnt_q) - ONE)); // R1

    AST_RELOAD_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RELOAD) |=> (cnt_q == ZERO && rel_q)); // R4

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_tick && op != OP_RELOAD) |=> ($stable(cnt_q) && $stable(rel_q))); // R8

endmodule

// File: rtl/line_irq_flag.sv
// Module: line_irq_flag
// Holds the interrupt enable and the pending flag. A disable write
// clears pending with top priority, a zero tick while enabled sets
// it, and a poll clears it otherwise. Enable changes take effect on
// the following cycle.
module line_irq_flag
    import line_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  irq_op_e op,
    input  logic    tick_zero,
    input  logic    poll_req,
    output logic    pending
);

    logic en_q;
    logic set_now;

    assign set_now = tick_zero && en_q;

    // Purpose: enable register from the enable/disable writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (op == OP_DISABLE)
            en_q <= 1'b0;
        else if (op == OP_ENABLE)
            en_q <= 1'b1;
    end

    // Purpose: pending flag with disable > set > poll priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (op == OP_DISABLE)
            pending <= 1'b0;
        else if (set_now)
            pending <= 1'b1;
        else if (poll_req)
            pending <= 1'b0;
    end

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DISABLE) |=> (!pending && !en_q)); // R5

    AST_ZERO_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_zero && en_q && op != OP_DISABLE) |=> pending); // R2

    AST_POLL_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_req && !tick_zero) |=> !pending); // R6

    AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !pending) |=> !pending); // R2

endmodule

// File: rtl/line_irq_counter.sv
// Module: line_irq_counter (top)
// Scanline interrupt down-counter: a write decoder, the counter with
// its reload latch, and the enable/pending flag. The interrupt line
// and the poll view both show the pending flag. Assumes line_tick is
// already a clean one-cycle pulse per scanline.
module line_irq_counter
    import line_irq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              poll_req,
    output logic              poll_pending,
    output logic              irq
);

    irq_op_e op;
    logic    tick_zero;
    logic    pending;

    line_irq_decode #(.ADDR_W(ADDR_W)) u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .op      (op)
    );

    line_irq_count #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .wr_data   (wr_data),
        .line_tick (line_tick),
        .tick_zero (tick_zero)
    );

    line_irq_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .tick_zero (tick_zero),
        .poll_req  (poll_req),
        .pending   (pending)
    );

    assign irq          = pending;
    assign poll_pending = pending;

    AST_OUT_OF_RANGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[ADDR_W-1 -: 2] != 2'b11 && !line_tick && !poll_req)
        |=> $stable(irq)); // R10

endmodule

// File: tb/tb_line_irq_counter.sv
module tb_line_irq_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        poll_req = 1'b0;
    logic        poll_pending;
    logic        irq;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    // bench model state
    logic [7:0] m_latch = '0, m_cnt = '0;
    logic       m_rel = 1'b0, m_en = 1'b0, m_pend = 1'b0;

    always #5 clk = ~clk;

    line_irq_counter dut (
        .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .poll_req(poll_req),
        .poll_pending(poll_pending), .irq(irq)
    );

    task automatic check(input logic act, input logic exp, input string req);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, update model, check after the edge.
    task automatic step(input logic t, input logic w, input logic [15:0] a,
                        input logic [7:0] d, input logic p, input string req);
        logic hit, cnt_wr, zero_tick;
        line_tick = t; wr_en = w; wr_addr = a; wr_data = d; poll_req = p;
        #1;
        if (p) check(poll_pending, m_pend, "R6 poll view");
        hit = w && (a[15:14] == 2'b11);          // R10 decode
        cnt_wr = hit && !a[13] && a[0];
        zero_tick = 1'b0;
        if (cnt_wr) begin                        // R4, R8
            m_cnt = 8'd0; m_rel = 1'b1;
        end else if (t) begin                    // R1
            if (m_rel || m_cnt == 8'd0) begin m_cnt = m_latch; m_rel = 1'b0; end
            else m_cnt = m_cnt - 8'd1;
            zero_tick = (m_cnt == 8'd0);
        end
        if (hit && a[13] && !a[0]) m_pend = 1'b0;          // R5
        else if (zero_tick && m_en) m_pend = 1'b1;         // R2
        else if (p) m_pend = 1'b0;                         // R6
        if (hit && !a[13] && !a[0]) m_latch = d;           // R3
        if (hit && a[13]) m_en = a[0];                     // R5
        @(posedge clk);
        @(negedge clk);
        line_tick = 1'b0; wr_en = 1'b0; poll_req = 1'b0;
        check(irq, m_pend, req);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(irq, 1'b0, "R9 reset irq");
        check(poll_pending, 1'b0, "R9 reset poll view");
        rst_n = 1'b1;
        @(negedge clk);
        // R9: disabled after reset, a tick gives no interrupt
        step(1'b1, 1'b0, 16'h0000, 8'h00, 1'b0, "R9 disabled after reset");
        // R7: latch zero, enabled, every tick pends
        step(1'b0, 1'b1, 16'hE001, 8'h00, 1'b0, "R5 enable");
        for (int i = 0; i < 4; i++) begin
            step(1'b1, 1'b0, 16'h0000, 8'h00, 1'b1, "R7 zero latch every tick");
        end
        step(1'b0, 1'b0, 16'h0000, 8'h00, 1'b1, "R6 poll clears");
        // Sweep: latch values 0..15, reload, 40 ticks with polls
        for (int v = 0; v < 16; v++) begin
            step(1'b0, 1'b1, 16'hC000, 8'(v), 1'b0, "R3 latch write");
            step(1'b0, 1'b1, 16'hC001, 8'h00, 1'b0, "R4 reload request");
            for (int k = 0; k < 40; k++) begin
                step(1'b1, 1'b0, 16'h0000, 8'h00, (k % 3) == 0, "R1 tick sweep");
            end
        end
        // R5: disable clears a pending flag and blocks setting
        step(1'b0, 1'b1, 16'hC000, 8'h00, 1'b0, "R3 latch zero");
        step(1'b1, 1'b0, 16'h0000, 8'h00, 1'b0, "R2 set");
        step(1'b1, 1'b1, 16'hE000, 8'h00, 1'b0, "R5 disable beats set");
        step(1'b1, 1'b0, 16'h0000, 8'h00, 1'b0, "R5 stays disabled");
        // R10: out-of-range writes
        step(1'b0, 1'b1, 16'hA001, 8'h00, 1'b0, "R10 ignored write");
        step(1'b1, 1'b1, 16'h6001, 8'h00, 1'b0, "R10 ignored write with tick");
        // R8: reload write together with tick, enabled
        step(1'b0, 1'b1, 16'hFFFF, 8'h00, 1'b0, "R5 enable odd high addr");
        step(1'b1, 1'b1, 16'hDFFF, 8'h00, 1'b0, "R8 reload write beats tick");
        step(1'b1, 1'b0, 16'h0000, 8'h00, 1'b0, "R8 next tick reloads");
        // Pseudo-random mix
        lfsr = 16'hACE1;
        for (int n = 0; n < 6000; n++) begin
            logic [15:0] a;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (lfsr[6:4])
                3'd0: a = 16'hC000 | {3'b000, lfsr[15:3], 1'b0} & 16'h1FFE;
                3'd1: a = 16'hC001;
                3'd2: a = 16'hE000;
                3'd3: a = 16'hE001 | {3'b000, lfsr[12:0]};
                3'd4: a = {2'b10, lfsr[13:0]};
                3'd5: a = {1'b0, lfsr[14:0]};
                default: a = 16'hC000;
            endcase
            step(lfsr[0], lfsr[3:1] < 3'd3, a, {5'd0, lfsr[9:7]}, lfsr[11] & lfsr[2],
                 "R1 R2 R8 mixed");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule